// File: doc/BRIEF.md
# Flash Byte-Program Sequencer

This block sits on the host side of a parallel flash device and carries out the byte-programming algorithm for it. Each byte request arrives on a valid/ready interface with an address, a data byte and a flag that marks the end of a run. For each byte the block issues a program-setup command write. It then issues a program write carrying the address and the data. It waits a program pulse that it times itself, then issues a program-verify command write that ends the pulse. After that it raises a read strobe, and in the following cycle it compares the byte the device returns with the intended data.

On a match the block reports a pass for that byte and is ready for the next one. On a mismatch it repeats the whole three-write sequence. When the attempt limit is used up without a match, it reports a fail and raises a sticky error that holds the failing address. While the error is set it refuses new requests, until the host clears it. After the last byte of a run passes, and after any failure, the block writes the read-mode command so the device goes back to normal reading.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, req_ready is 1 and fl_we, fl_re, res_valid and err are all 0.
- R2: One cycle after a request is accepted, fl_we is 1 with fl_wdata = 0x40 (program setup) and fl_addr = the request address. In the very next cycle, fl_we is 1 with fl_wdata = the request data at the same address. fl_we and fl_re are never 1 together.
- R3: The program-verify write (fl_we = 1, fl_wdata = 0xC0) comes exactly PULSE_CYC cycles after the program write. The cycle after the verify write has fl_re = 1 and fl_we = 0.
- R4: In the cycle after fl_re, the block compares fl_rdata with the request data. If they are equal, res_valid = 1 and res_pass = 1 for that one cycle, with res_addr = the address and res_tries = the number of program writes made for this byte.
- R5: On a mismatch while res_tries < MAX_TRIES, no result is reported. The block starts the sequence again with a new setup write, so the number of setup writes for a byte equals its final res_tries.
- R6: On a mismatch after MAX_TRIES (default 25) program writes, the block reports res_valid = 1 and res_pass = 0 with res_tries = MAX_TRIES. From the next cycle, err = 1 and err_addr = the failing address.
- R7: The attempt count starts again from zero for each accepted byte, so a byte that passes on its first write reports res_tries = 1 whatever came before it.
- R8: A read-mode command write (fl_we = 1, fl_wdata = 0x00) follows a pass of a byte whose last flag is set, and it follows every fail. A pass of a byte whose last flag is clear issues none.
- R9: A one-cycle err_clear brings err to 0 and req_ready back to 1.
- R10: While err = 1, req_ready is 0, and req_valid causes no flash write at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Byte request present |
| req_ready | output | 1 | Block can accept a byte |
| req_addr | input | AW | Byte address |
| req_data | input | DW | Byte to program |
| req_last | input | 1 | Last byte of a run |
| res_valid | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | Byte verified |
| res_addr | output | AW | Address of the reported byte |
| res_tries | output | TW | Program writes spent on the byte |
| err | output | 1 | Sticky failure flag |
| err_addr | output | AW | Address that failed |
| err_clear | input | 1 | Clears err |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data or command |
| fl_rdata | input | DW | Flash read data, valid the cycle after fl_re |

## Verification
A sequencer state that is wrong shows up within a cycle or two as a write that is out of order on fl_we/fl_wdata: a program write with no setup write before it, a verify write with no read after it, or a read-mode write that is missing or extra. A wrong pulse timer shows up as a gap between the program write and the verify write that is not PULSE_CYC, and this is visible on the first attempt. A wrong attempt counter shows up as a res_tries that does not match the number of setup writes, or as a fail reported one attempt early or late at the limit. The flash model in the bench makes each byte need a chosen number of pulses, so the limit and the cases around it can be reached.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_PROG,
    S_WAIT,
    S_VERIFY,
    S_READ,
    S_CMP,
    S_RDCMD
  } seq_state_t;

  localparam logic [7:0] CMD_PGM_SETUP  = 8'h40;
  localparam logic [7:0] CMD_PGM_VERIFY = 8'hC0;
  localparam logic [7:0] CMD_READ_MODE  = 8'h00;

endpackage

// File: rtl/fps_pulse_timer.sv
module fps_pulse_timer #(
  parameter int PULSE_CYC = 2500,
  localparam int CW = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    if (start) cnt_d = CW'(PULSE_CYC - 1);
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == CW'(1));

  // a new pulse never starts while one is still being timed
  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cnt_q == '0));

endmodule

// File: rtl/fps_try_counter.sv
module fps_try_counter #(
  parameter int MAX_TRIES = 25,
  localparam int TW = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  output logic [TW-1:0] count,
  output logic          at_max
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear || inc;
    if (clear) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count  = cnt_q;
  assign at_max = (cnt_q == TW'(MAX_TRIES));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(MAX_TRIES));

  p_no_inc_at_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clear) |-> !at_max);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int PULSE_CYC = 2500,
  parameter int MAX_TRIES = 25,
  localparam int TW = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_last,
  output logic          res_valid,
  output logic          res_pass,
  output logic [AW-1:0] res_addr,
  output logic [TW-1:0] res_tries,
  output logic          err,
  output logic [AW-1:0] err_addr,
  input  logic          err_clear,
  output logic          fl_we,
  output logic          fl_re,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata
);

  seq_state_t    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          last_q;
  logic          err_q, err_d;
  logic [AW-1:0] err_addr_q;
  logic          accept, match, give_up, timer_done;
  logic [TW-1:0] tries;
  logic          tries_max;

  fps_pulse_timer #(.PULSE_CYC(PULSE_CYC)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (state_q == S_PROG),
    .done  (timer_done)
  );

  fps_try_counter #(.MAX_TRIES(MAX_TRIES)) tries_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .inc    (state_q == S_PROG),
    .count  (tries),
    .at_max (tries_max)
  );

  assign req_ready = (state_q == S_IDLE) && !err_q;
  assign accept    = req_valid && req_ready;
  assign match     = (fl_rdata == data_q);
  assign give_up   = !match && tries_max;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (accept) state_d = S_SETUP;
      S_SETUP:  state_d = S_PROG;
      S_PROG:   state_d = S_WAIT;
      S_WAIT:   if (timer_done) state_d = S_VERIFY;
      S_VERIFY: state_d = S_READ;
      S_READ:   state_d = S_CMP;
      S_CMP: begin
        if (match)        state_d = last_q ? S_RDCMD : S_IDLE;
        else if (give_up) state_d = S_RDCMD;
        else              state_d = S_SETUP;
      end
      S_RDCMD:  state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_comb begin
    err_d = err_q;
    if (err_clear)                      err_d = 1'b0;
    if ((state_q == S_CMP) && give_up)  err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      addr_q     <= '0;
      data_q     <= '0;
      last_q     <= 1'b0;
      err_q      <= 1'b0;
      err_addr_q <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_data;
        last_q <= req_last;
      end
      if ((state_q == S_CMP) && give_up) err_addr_q <= addr_q;
    end
  end

  always_comb begin
    fl_we    = 1'b0;
    fl_wdata = '0;
    unique case (state_q)
      S_SETUP:  begin fl_we = 1'b1; fl_wdata = DW'(CMD_PGM_SETUP);  end
      S_PROG:   begin fl_we = 1'b1; fl_wdata = data_q;              end
      S_VERIFY: begin fl_we = 1'b1; fl_wdata = DW'(CMD_PGM_VERIFY); end
      S_RDCMD:  begin fl_we = 1'b1; fl_wdata = DW'(CMD_READ_MODE);  end
      default:  ;
    endcase
  end

  assign fl_re     = (state_q == S_READ);
  assign fl_addr   = addr_q;
  assign res_valid = (state_q == S_CMP) && (match || tries_max);
  assign res_pass  = match;
  assign res_addr  = addr_q;
  assign res_tries = tries;
  assign err       = err_q;
  assign err_addr  = err_addr_q;

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  p_prog_after_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PROG) |-> ($past(state_q) == S_SETUP));

  p_read_after_verify_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fl_re |-> ($past(state_q) == S_VERIFY));

  p_fail_sets_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_pass) |=> err);

  p_err_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !req_ready);

endmodule

// File: tb/flash_prog_seq_tb_top.sv
module flash_prog_seq_tb_top;

  localparam int AW    = 15;
  localparam int DW    = 8;
  localparam int PULSE = 16;
  localparam int MAXT  = 25;
  localparam int TW    = $clog2(MAXT + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_last = 1'b0;
  logic          res_valid, res_pass;
  logic [AW-1:0] res_addr, err_addr;
  logic [TW-1:0] res_tries;
  logic          err;
  logic          err_clear = 1'b0;
  logic          fl_we, fl_re;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic [DW-1:0] fl_rdata;

  always #2 clk = ~clk;

  flash_prog_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE), .MAX_TRIES(MAXT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_last(req_last),
    .res_valid(res_valid), .res_pass(res_pass), .res_addr(res_addr),
    .res_tries(res_tries), .err(err), .err_addr(err_addr), .err_clear(err_clear),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata)
  );

  // flash model: a byte takes effect only after need_pulses program writes
  logic [DW-1:0] mem [16];
  int cyc = 0, prog_cyc = 0, gap = 0;
  int setup_cnt = 0, rdcmd_cnt = 0, wr_total = 0, bad_order = 0, need_left = 0;
  logic prev_setup = 1'b0;
  logic [AW-1:0] setup_addr = '0;
  int need_pulses = 1;
  logic [AW-1:0] cur_addr;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '1;
    fl_rdata = '0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fl_we) wr_total <= wr_total + 1;
    if (prev_setup) begin
      if (!fl_we || fl_addr != setup_addr || fl_wdata != req_data_q) bad_order <= bad_order + 1;
      if (fl_we) begin
        prog_cyc <= cyc;
        if (need_left <= 1) mem[fl_addr[3:0]] <= mem[fl_addr[3:0]] & fl_wdata;
        need_left <= need_left - 1;
      end
      prev_setup <= 1'b0;
    end else if (fl_we) begin
      if (fl_wdata == 8'h40) begin
        setup_cnt  <= setup_cnt + 1;
        prev_setup <= 1'b1;
        setup_addr <= fl_addr;
        if (fl_addr != cur_addr) bad_order <= bad_order + 1;
      end else if (fl_wdata == 8'hC0) begin
        gap <= cyc - prog_cyc;
      end else if (fl_wdata == 8'h00) begin
        rdcmd_cnt <= rdcmd_cnt + 1;
      end
    end
    if (fl_re) fl_rdata <= mem[fl_addr[3:0]];
    if (load_need) need_left <= need_pulses;
  end

  logic [DW-1:0] req_data_q = '0;
  logic load_need = 1'b0;

  int checks = 0, errors = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0] addr;
    logic [7:0] data;
    logic       last;
    logic [5:0] need;
    logic [5:0] tries;
    logic       pass;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{4'd1, 8'h5A, 1'b0, 6'd1,  6'd1,  1'b1},
    '{4'd2, 8'h3C, 1'b1, 6'd3,  6'd3,  1'b1},
    '{4'd3, 8'h00, 1'b0, 6'd25, 6'd25, 1'b1},
    '{4'd4, 8'h81, 1'b1, 6'd1,  6'd1,  1'b1},
    '{4'd5, 8'h12, 1'b0, 6'd30, 6'd25, 1'b0}
  };

  task automatic run_byte(input vec_t v);
    int s0, r0, guard;
    s0 = setup_cnt; r0 = rdcmd_cnt; guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
    need_pulses = v.need; load_need = 1'b1;
    cur_addr = AW'(v.addr); req_data_q = v.data;
    req_valid = 1'b1; req_addr = AW'(v.addr); req_data = v.data; req_last = v.last;
    @(negedge clk);
    load_need = 1'b0; req_valid = 1'b0;
    guard = 0;
    while (!res_valid && guard < 5000) begin @(negedge clk); guard++; end
    check("R4 result strobe", res_valid, 1);
    check(v.pass ? "R4 pass flag" : "R6 fail flag", res_pass, v.pass);
    check("R4 result address", res_addr, v.addr);
    check(v.tries == 1 ? "R7 tries" : "R5 tries", res_tries, v.tries);
    check("R3 pulse gap", gap, PULSE);
    check("R5 setup writes", setup_cnt - s0, v.tries);
    check("R2 write order", bad_order, 0);
    guard = 0;
    @(negedge clk);
    while (!req_ready && !err && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    check("R8 read-mode writes", rdcmd_cnt - r0, (v.last || !v.pass) ? 1 : 0);
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    check("R1 ready", req_ready, 1);
    check("R1 we", fl_we, 0);
    check("R1 re", fl_re, 0);
    check("R1 err", err, 0);
    check("R1 res_valid", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 5; k++) run_byte(VEC[k]);
    check("R6 err set", err, 1);
    check("R6 err address", err_addr, 5);
    check("R10 ready low", req_ready, 0);
    w0 = wr_total;
    req_valid = 1'b1; req_addr = AW'(7); req_data = 8'h11; req_last = 1'b1;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    check("R10 no writes while err", wr_total - w0, 0);
    check("R10 err held", err, 1);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    @(negedge clk);
    check("R9 err cleared", err, 0);
    check("R9 ready back", req_ready, 1);
    run_byte('{4'd6, 8'h77, 1'b1, 6'd1, 6'd1, 1'b1});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule